// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs exception entry for a simple 32-bit RISC core that keeps its exception state in coprocessor-style status, cause and exception-PC registers. When the pipeline raises an exception request, it supplies an exception code, the PC of the faulting instruction, a flag saying that instruction sits in a branch delay slot, and the number of a coprocessor that was used without permission. In the following cycle the block presents a one-cycle redirect pulse with the new fetch address. The status, cause and exception-PC registers show their updated values in that same cycle.

Two request codes stand for TLB refill misses. The block folds them into the ordinary TLB load and TLB store codes. A refill taken outside an exception handler uses the dedicated refill vector. A refill taken inside a handler uses the general vector. A nested exception, taken while the exception-level bit is already set, still records its code. It does not change the saved PC, the branch-delay flag or the level bit. A simple write port lets software load the status and cause registers, for example to clear the exception-level bit at the end of a handler.

Top module: `trap_entry_unit`

## Requirements
- R1: Synchronous reset (rst high) sets status to 0x00400002, which has the boot-vector bit 22 and the exception-level bit 1 set. Reset clears cause, EPC, redirectValid and delaySlotClear.
- R2: An exception request sampled at a clock edge gives redirectValid high for exactly the next cycle, together with redirectAddr. The EPC, cause and status updates are visible in that same cycle.
- R3: The vector base is 0xBFC00200 when status bit 22 is set and 0x80000000 otherwise. The target is base plus offset, and the offset is 0x180 for ordinary exceptions.
- R4: Request code 30 (load refill) is recorded as cause code 2 and request code 31 (store refill) as cause code 3. A refill uses offset 0x000 when status bit 1 is clear and 0x180 when it is set.
- R5: Every exception clears cause bit 31 and cause bits 7:0, then writes the recorded code into bits 6:2. The remaining cause bits are kept.
- R6: For code 11 (coprocessor unusable), badCopNum is written into cause bits 29:28, replacing their old value.
- R7: With status bit 1 clear, an exception sets status bit 1. If inDelaySlot is low, EPC gets excPc. If it is high, EPC gets excPc minus 4, cause bit 31 is set and delaySlotClear pulses.
- R8: With status bit 1 set, an exception leaves EPC unchanged, leaves cause bit 31 clear and status bit 1 set, and keeps delaySlotClear low. The code is still written.
- R9: With altIntVector high, an interrupt (code 0) uses offset 0x200 instead of 0x180.
- R10: regWrEn writes regWrData into status (regWrSel 0) or cause (regWrSel 1). In a cycle that also has an exception request, the exception wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| excReq | input | 1 | Exception request strobe |
| excCode | input | 5 | Request code (30/31 are refill requests) |
| excPc | input | 32 | PC of the faulting instruction |
| inDelaySlot | input | 1 | Faulting instruction is in a branch delay slot |
| badCopNum | input | 2 | Coprocessor number for code 11 |
| altIntVector | input | 1 | Variant select: interrupts use offset 0x200 |
| regWrEn | input | 1 | Software register write enable |
| regWrSel | input | 1 | 0 selects status, 1 selects cause |
| regWrData | input | 32 | Write data |
| redirectValid | output | 1 | One-cycle redirect pulse |
| redirectAddr | output | 32 | Exception vector target |
| delaySlotClear | output | 1 | Pulse telling the pipeline to drop pending delay-slot state |
| epcOut | output | 32 | Exception PC register |
| causeOut | output | 32 | Cause register |
| statusOut | output | 32 | Status register |

## Verification
Exceptions are issued with the level bit both clear and set. This separates the nested path (EPC frozen, no delay-slot flag, refill sent to the general vector) from the first-entry path. Delay-slot and non-delay-slot faults tell the PC-minus-4 correction apart from a plain copy. Load and store refills, a coprocessor-unusable fault with a preloaded all-ones cause, and interrupts with the variant select both high and low show the code folding, the field masking and the offset choice. The boot-vector bit is toggled under both bases. A write issued in the same cycle as an exception checks which one has priority.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  localparam int XLEN      = 32;
  localparam int CODE_W    = 5;
  localparam int OFF_W     = 12;
  localparam int STAT_EXL  = 1;
  localparam int STAT_BEV  = 22;
  localparam int CAUSE_BD  = 31;
  localparam int CAUSE_CE  = 28;

  localparam logic [CODE_W-1:0] CODE_INT       = 5'd0;
  localparam logic [CODE_W-1:0] CODE_TLB_LD    = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLB_ST    = 5'd3;
  localparam logic [CODE_W-1:0] CODE_COP_UNUSE = 5'd11;
  localparam logic [CODE_W-1:0] REQ_REFILL_LD  = 5'd30;
  localparam logic [CODE_W-1:0] REQ_REFILL_ST  = 5'd31;

  localparam logic [OFF_W-1:0] OFF_REFILL  = 12'h000;
  localparam logic [OFF_W-1:0] OFF_GENERAL = 12'h180;
  localparam logic [OFF_W-1:0] OFF_INT_ALT = 12'h200;

  typedef struct packed {
    logic              takeExc;
    logic              loadEpc;
    logic              epcBack;
    logic              setBd;
    logic              setExl;
    logic              loadCe;
    logic [CODE_W-1:0] code;
    logic [OFF_W-1:0]  offset;
  } ctlStrobe_t;
endpackage

// File: rtl/trap_ctrl.sv
`timescale 1ns/1ps
module trap_ctrl
  import trap_pkg::*;
#(
  parameter bit ALT_INT_ENABLE = 1'b1
) (
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              inDelaySlot,
  input  logic              altIntVector,
  input  logic              exlNow,
  output ctlStrobe_t        strobe
);
  logic isRefill;
  logic altSel;

  generate
    if (ALT_INT_ENABLE) begin : g_alt
      assign altSel = altIntVector;
    end else begin : g_noalt
      assign altSel = 1'b0;
    end
  endgenerate

  assign isRefill = (excCode == REQ_REFILL_LD) || (excCode == REQ_REFILL_ST);

  always_comb begin
    strobe         = '0;
    strobe.takeExc = excReq;
    if (isRefill)
      strobe.code = (excCode == REQ_REFILL_LD) ? CODE_TLB_LD : CODE_TLB_ST;
    else
      strobe.code = excCode;
    strobe.loadCe  = excReq && (excCode == CODE_COP_UNUSE);
    if (isRefill && !exlNow)
      strobe.offset = OFF_REFILL;
    else if (altSel && (excCode == CODE_INT))
      strobe.offset = OFF_INT_ALT;
    else
      strobe.offset = OFF_GENERAL;
    strobe.loadEpc = excReq && !exlNow;
    strobe.epcBack = inDelaySlot;
    strobe.setBd   = excReq && !exlNow && inDelaySlot;
    strobe.setExl  = excReq && !exlNow;
  end
endmodule

// File: rtl/trap_regs.sv
`timescale 1ns/1ps
module trap_regs
  import trap_pkg::*;
#(
  parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] RAM_BASE    = 32'h8000_0000,
  parameter logic [XLEN-1:0] RESET_STAT  = 32'h0040_0002
) (
  input  logic            clk,
  input  logic            rst,
  input  ctlStrobe_t      strobe,
  input  logic [XLEN-1:0] excPc,
  input  logic [1:0]      badCopNum,
  input  logic            regWrEn,
  input  logic            regWrSel,
  input  logic [XLEN-1:0] regWrData,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectAddr,
  output logic            delaySlotClear,
  output logic [XLEN-1:0] epcQ,
  output logic [XLEN-1:0] causeQ,
  output logic [XLEN-1:0] statusQ
);
  localparam logic [XLEN-1:0] CAUSE_CLR = 32'h8000_00FF;
  localparam logic [XLEN-1:0] CE_MASK   = 32'h3 << CAUSE_CE;

  logic [XLEN-1:0] nextCause;
  logic [XLEN-1:0] vecBase;

  assign vecBase = statusQ[STAT_BEV] ? BOOT_BASE : RAM_BASE;

  always_comb begin
    nextCause = (causeQ & ~CAUSE_CLR) | ({{(XLEN-CODE_W){1'b0}}, strobe.code} << 2);
    if (strobe.loadCe)
      nextCause = (nextCause & ~CE_MASK) | ({{(XLEN-2){1'b0}}, badCopNum} << CAUSE_CE);
    if (strobe.setBd)
      nextCause[CAUSE_BD] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ        <= RESET_STAT;
      causeQ         <= '0;
      epcQ           <= '0;
      redirectValid  <= 1'b0;
      redirectAddr   <= '0;
      delaySlotClear <= 1'b0;
    end else begin
      redirectValid  <= strobe.takeExc;
      delaySlotClear <= strobe.setBd;
      if (strobe.takeExc) begin
        redirectAddr <= vecBase + {{(XLEN-OFF_W){1'b0}}, strobe.offset};
        causeQ       <= nextCause;
        if (strobe.loadEpc)
          epcQ <= strobe.epcBack ? excPc - 32'd4 : excPc;
        if (strobe.setExl)
          statusQ[STAT_EXL] <= 1'b1;
      end else if (regWrEn) begin
        if (regWrSel) causeQ  <= regWrData;
        else          statusQ <= regWrData;
      end
    end
  end

  // R2
  redirect_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> $past(strobe.takeExc));
  // R7
  exl_set_after_entry_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.takeExc |=> statusQ[STAT_EXL]);
  // R8
  nested_epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.takeExc && statusQ[STAT_EXL]) |=> ($stable(epcQ) && !causeQ[CAUSE_BD] && !delaySlotClear));
  // R7
  bd_pulse_match_chk: assert property (@(posedge clk) disable iff (rst)
    (redirectValid && causeQ[CAUSE_BD]) |-> delaySlotClear);
endmodule

// File: rtl/trap_entry_unit.sv
`timescale 1ns/1ps
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter bit ALT_INT_ENABLE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        excReq,
  input  logic [4:0]  excCode,
  input  logic [31:0] excPc,
  input  logic        inDelaySlot,
  input  logic [1:0]  badCopNum,
  input  logic        altIntVector,
  input  logic        regWrEn,
  input  logic        regWrSel,
  input  logic [31:0] regWrData,
  output logic        redirectValid,
  output logic [31:0] redirectAddr,
  output logic        delaySlotClear,
  output logic [31:0] epcOut,
  output logic [31:0] causeOut,
  output logic [31:0] statusOut
);
  ctlStrobe_t strobe;

  trap_ctrl #(.ALT_INT_ENABLE(ALT_INT_ENABLE)) u_ctrl (
    .excReq       (excReq),
    .excCode      (excCode),
    .inDelaySlot  (inDelaySlot),
    .altIntVector (altIntVector),
    .exlNow       (statusOut[STAT_EXL]),
    .strobe       (strobe)
  );

  trap_regs u_regs (
    .clk            (clk),
    .rst            (rst),
    .strobe         (strobe),
    .excPc          (excPc),
    .badCopNum      (badCopNum),
    .regWrEn        (regWrEn),
    .regWrSel       (regWrSel),
    .regWrData      (regWrData),
    .redirectValid  (redirectValid),
    .redirectAddr   (redirectAddr),
    .delaySlotClear (delaySlotClear),
    .epcQ           (epcOut),
    .causeQ         (causeOut),
    .statusQ        (statusOut)
  );

  // R4
  refill_ld_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (excReq && excCode == REQ_REFILL_LD) |=> (causeOut[6:2] == CODE_TLB_LD));
  // R4
  refill_st_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (excReq && excCode == REQ_REFILL_ST) |=> (causeOut[6:2] == CODE_TLB_ST));
endmodule

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        excReq = 1'b0;
  logic [4:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic        inDelaySlot = 1'b0;
  logic [1:0]  badCopNum = '0;
  logic        altIntVector = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regWrSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic        redirectValid, delaySlotClear;
  logic [31:0] redirectAddr, epcOut, causeOut, statusOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] epc;
    logic [31:0] cause;
    logic [31:0] status;
    logic        dsc;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  logic [31:0] mStatus = 32'h0040_0002;
  logic [31:0] mCause  = '0;
  logic [31:0] mEpc    = '0;

  trap_entry_unit u_dut (
    .clk(clk), .rst(rst), .excReq(excReq), .excCode(excCode), .excPc(excPc),
    .inDelaySlot(inDelaySlot), .badCopNum(badCopNum), .altIntVector(altIntVector),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .redirectValid(redirectValid), .redirectAddr(redirectAddr),
    .delaySlotClear(delaySlotClear), .epcOut(epcOut), .causeOut(causeOut),
    .statusOut(statusOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: computes expected outcome from the requirements and queues it
  task automatic doExc(input logic [4:0] code, input logic [31:0] pc,
                       input logic ds, input logic [1:0] bad, input logic alt,
                       input logic withWrite, input string tag);
    expItem_t it;
    logic exl, refill;
    logic [4:0] mapped;
    logic [11:0] off;
    logic [31:0] c;
    exl    = mStatus[1];
    refill = (code == 5'd30) || (code == 5'd31);
    mapped = refill ? code - 5'd28 : code;
    if (refill && !exl)            off = 12'h000;
    else if (alt && code == 5'd0)  off = 12'h200;
    else                           off = 12'h180;
    it.addr = (mStatus[22] ? 32'hBFC0_0200 : 32'h8000_0000) + {20'd0, off};
    c = (mCause & ~32'h8000_00FF) | ({27'd0, mapped} << 2);
    if (mapped == 5'd11) c = (c & ~32'h3000_0000) | ({30'd0, bad} << 28);
    it.dsc = 1'b0;
    if (!exl) begin
      if (ds) begin mEpc = pc - 32'd4; c[31] = 1'b1; it.dsc = 1'b1; end
      else mEpc = pc;
      mStatus[1] = 1'b1;
    end
    mCause = c;
    it.epc = mEpc; it.cause = mCause; it.status = mStatus; it.tag = tag;
    scoreQ.push_back(it);
    excReq = 1'b1; excCode = code; excPc = pc; inDelaySlot = ds;
    badCopNum = bad; altIntVector = alt;
    if (withWrite) begin regWrEn = 1'b1; regWrSel = 1'b0; regWrData = 32'h0; end
    @(negedge clk);
    excReq = 1'b0; regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic doWrite(input logic sel, input logic [31:0] data);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel) mCause = data; else mStatus = data;
  endtask

  // Monitor: pops the expected item when the redirect pulse appears
  always @(negedge clk) begin
    if (!rst && !finished && redirectValid) begin
      if (scoreQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected redirect: actual 1 expected 0");
      end else begin
        expItem_t e;
        e = scoreQ.pop_front();
        check(e.tag, "redirectAddr", redirectAddr, e.addr);
        check(e.tag, "epc", epcOut, e.epc);
        check(e.tag, "cause", causeOut, e.cause);
        check(e.tag, "status", statusOut, e.status);
        check(e.tag, "delaySlotClear", {31'd0, delaySlotClear}, {31'd0, e.dsc});
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "status", statusOut, 32'h0040_0002);
    check("R1", "cause", causeOut, 32'h0);
    check("R1", "epc", epcOut, 32'h0);
    check("R1", "redirectValid", {31'd0, redirectValid}, 32'h0);
    // R8 nested after reset: boot base, EPC frozen, general offset (R3)
    doExc(5'd4, 32'h0000_0100, 1'b1, 2'd0, 1'b0, 1'b0, "R8_nested_boot");
    // R4 non-nested load refill, RAM base, offset 0
    doWrite(1'b0, 32'h0);
    doExc(5'd30, 32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0, "R4_refill_ld");
    // R8 nested store refill goes to general vector, no BD
    doExc(5'd31, 32'h0000_2000, 1'b1, 2'd0, 1'b0, 1'b0, "R8_nested_refill");
    // R6 R7 delay-slot coprocessor-unusable
    doWrite(1'b0, 32'h0);
    doExc(5'd11, 32'h0000_3004, 1'b1, 2'd2, 1'b0, 1'b0, "R6_R7_cop_ds");
    // R9 alternate interrupt offset, then default
    doWrite(1'b0, 32'h0);
    doExc(5'd0, 32'h0000_4000, 1'b0, 2'd0, 1'b1, 1'b0, "R9_int_alt");
    doWrite(1'b0, 32'h0);
    doExc(5'd0, 32'h0000_4100, 1'b0, 2'd0, 1'b0, 1'b0, "R3_int_default");
    // R5 R10 preloaded cause masking
    doWrite(1'b1, 32'hFFFF_FFFF);
    check("R10", "cause write", causeOut, 32'hFFFF_FFFF);
    doWrite(1'b0, 32'h0);
    doExc(5'd12, 32'h0000_5000, 1'b0, 2'd0, 1'b0, 1'b0, "R5_mask_keep");
    doWrite(1'b1, 32'hFFFF_FFFF);
    doWrite(1'b0, 32'h0);
    doExc(5'd11, 32'h0000_5100, 1'b0, 2'd1, 1'b0, 1'b0, "R6_ce_replace");
    // R3 R4 boot base refill with level clear
    doWrite(1'b0, 32'h0040_0000);
    doExc(5'd31, 32'h0000_6000, 1'b0, 2'd0, 1'b0, 1'b0, "R4_refill_boot");
    // R10 write in same cycle as exception is dropped
    doExc(5'd5, 32'h0000_7000, 1'b0, 2'd0, 1'b0, 1'b1, "R10_exc_wins");
    check("R10", "status after drop", statusOut, mStatus);
    @(negedge clk);
    check("R2", "redirect single pulse", {31'd0, redirectValid}, 32'h0);
    check("R2", "queue drained", scoreQ.size(), 32'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule